// File: doc/BRIEF.md
# LCD Pixel Unpacker with Color Lookup

This block sits between a display frame-buffer fetch path and a panel timing generator. It takes in 32-bit frame-buffer words over a valid/ready handshake. Each time the panel side raises a request, it produces one pixel. The pixel is presented one clock later as 8-bit red, green and blue with a valid flag. Pixel depth can be 1, 2, 4, 8, 16 or 24 bits. Depths of 8 bits and below are indices into a 256-entry table of 16-bit colors. The 16-bit depth is direct 5:6:5 color. The 24-bit depth takes the low three bytes of the word as they are.

Three static controls shape the decode. One reverses the bytes of each word. One makes sub-byte pixels start from the top of each byte. One exchanges red and blue at the output. The color table is loaded through a write strobe. Each write carries two table entries. When the panel asks for a pixel and no word is held, the block raises a one-cycle underflow pulse instead of a pixel.

Top module: `lcd_pixel_unpacker`

## Requirements
- R1: After reset, pix_valid and underflow are 0 and word_ready is 1.
- R2: cfg_depth selects the bits per pixel and the pixels per word: 0→1 bit/32 pixels, 1→2/16, 2→4/8, 3→8/4, 4→16/2, 5→24/1. Codes 6 and 7 behave as code 5.
- R3: Once a word is accepted, word_ready stays 0 until the request for that word's last pixel. No second word is taken while pixels of the held word remain.
- R4: With cfg_pix_msb=0, pixel i of a word occupies bits [i*bpp +: bpp] of the (possibly byte-reversed) word. With cfg_pix_msb=1 and depth 1, 2 or 4 bits, pixels inside each byte are taken from bit 7 downward, and bytes are still taken from byte 0 upward. At 8, 16 and 24 bits, cfg_pix_msb has no effect.
- R5: cfg_byte_rev=1 reverses the four bytes of each word (bits 7:0 swap with 31:24, and 15:8 swap with 23:16) before any pixel is extracted.
- R6: At depths of 8 bits and below, the extracted field, zero-extended, indexes the color table. The entry is 5:6:5 (red 15:11, green 10:5, blue 4:0). Each component widens to 8 bits by repeating its top bits below it.
- R7: At 16 bits, pixel 0 is bits 15:0 and pixel 1 is bits 31:16, each decoded as 5:6:5 in the same way as R6. At 24 bits, red is bits 23:16, green 15:8 and blue 7:0.
- R8: cfg_rb_swap=1 exchanges the red and blue output components. Green is unchanged.
- R9: A write with pal_we=1 at address a stores pal_wdata[15:0] in entry 2a and pal_wdata[31:16] in entry 2a+1.
- R10: A pix_req while a word is held gives pix_valid=1 with that pixel on the next cycle. A pix_req with no word held gives underflow=1 and pix_valid=0 on the next cycle.
- R11: word_ready is 1 in the same cycle that the last pixel of the held word is requested, so a new word can be taken with no gap in pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_depth | input | 3 | Pixel depth code |
| cfg_byte_rev | input | 1 | Reverse bytes within each word |
| cfg_pix_msb | input | 1 | Sub-byte pixels taken from the top of each byte first |
| cfg_rb_swap | input | 1 | Exchange red and blue at the output |
| word_valid | input | 1 | Frame-buffer word offered |
| word_data | input | 32 | Frame-buffer word |
| word_ready | output | 1 | Word is taken when this and word_valid are both 1 |
| pix_req | input | 1 | Panel requests one pixel |
| pix_valid | output | 1 | pix_rgb holds a new pixel |
| pix_rgb | output | 24 | Pixel, red in 23:16, green 15:8, blue 7:0 |
| underflow | output | 1 | Pixel requested with no word held |
| pal_we | input | 1 | Color table write strobe |
| pal_waddr | input | 7 | Color table entry-pair address |
| pal_wdata | input | 32 | Two color table entries |

## Verification
The bench targets the mirror arithmetic for sub-byte pixels when the pixel order is from the top of the byte. A wrong mirror would give the correct pixel count but the pixels in the wrong order, and would show up only at 1, 2 and 4 bits. It feeds byte reversal at both table and direct depths, where a swap applied after extraction would scramble 16-bit halves. It loads the table with distinct values in both halves of each write, so even/odd entry crossing shows up as wrong colors. It checks the handshake at the exact last-pixel request: a design that drops ready one pixel early or late either loses a word or underflows on back-to-back words. It also checks that a request with no word gives an underflow pulse and no pixel.

// File: rtl/lpu_pkg.sv
package lpu_pkg;
  localparam int WORD_W  = 32;
  localparam int COLOR_W = 16;
  localparam int IDX_W   = 5;

  typedef logic [2:0] depth_t;
  localparam depth_t DEPTH_1  = 3'd0;
  localparam depth_t DEPTH_2  = 3'd1;
  localparam depth_t DEPTH_4  = 3'd2;
  localparam depth_t DEPTH_8  = 3'd3;
  localparam depth_t DEPTH_16 = 3'd4;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  function automatic logic [IDX_W-1:0] last_index(input depth_t d);
    case (d)
      DEPTH_1:  last_index = 5'd31;
      DEPTH_2:  last_index = 5'd15;
      DEPTH_4:  last_index = 5'd7;
      DEPTH_8:  last_index = 5'd3;
      DEPTH_16: last_index = 5'd1;
      default:  last_index = 5'd0;
    endcase
  endfunction

  function automatic rgb_t widen565(input logic [COLOR_W-1:0] c);
    rgb_t o;
    o.r = {c[15:11], c[15:13]};
    o.g = {c[10:5], c[10:9]};
    o.b = {c[4:0], c[4:2]};
    return o;
  endfunction
endpackage

// File: rtl/lpu_rst_sync.sv
module lpu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/lpu_palette.sv
module lpu_palette #(
  parameter int ENTRIES = 256
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic [$clog2(ENTRIES)-2:0]  waddr,
  input  logic [31:0]                 wdata,
  input  logic [$clog2(ENTRIES)-1:0]  raddr,
  output logic [lpu_pkg::COLOR_W-1:0] rdata
);
  localparam int AW    = $clog2(ENTRIES);
  localparam int PAIRS = ENTRIES / 2;

  logic [lpu_pkg::COLOR_W-1:0] mem_q [ENTRIES];

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic hit;
    assign hit = we && (waddr == (AW-1)'(p));
    always_ff @(posedge clk) begin
      if (hit) begin
        mem_q[2*p]   <= wdata[15:0];
        mem_q[2*p+1] <= wdata[31:16];
      end
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/lpu_word_buf.sv
module lpu_word_buf
  import lpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  depth_t            depth,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_ready,
  input  logic              pix_req,
  output logic [WORD_W-1:0] cur_word,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              consume,
  output logic              starve
);
  logic              have_q, have_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              last, accept;

  always_comb begin
    last       = (idx_q == last_index(depth));
    consume    = pix_req && have_q;
    starve     = pix_req && !have_q;
    word_ready = !have_q || (consume && last);
    accept     = word_valid && word_ready;
    have_d     = have_q;
    word_d     = word_q;
    idx_d      = idx_q;
    if (accept) begin
      have_d = 1'b1;
      word_d = word_data;
      idx_d  = '0;
    end else if (consume && last) begin
      have_d = 1'b0;
    end else if (consume) begin
      idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      word_q <= '0;
      idx_q  <= '0;
    end else begin
      have_q <= have_d;
      if (accept || consume) begin
        word_q <= word_d;
        idx_q  <= idx_d;
      end
    end
  end

  assign cur_word = word_q;
  assign cur_idx  = idx_q;
endmodule

// File: rtl/lpu_pixel_select.sv
module lpu_pixel_select
  import lpu_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [IDX_W-1:0]  idx,
  input  depth_t            depth,
  input  logic              byte_rev,
  input  logic              pix_msb,
  output logic              use_table,
  output logic [7:0]        table_idx,
  output logic [15:0]       half_pix,
  output logic [23:0]       true_pix
);
  logic [WORD_W-1:0] sw;
  logic [1:0]        lg;
  logic [4:0]        base;
  logic [2:0]        span_m1;
  logic [2:0]        in_byte;
  logic [4:0]        off;
  logic [WORD_W-1:0] shifted;
  logic [7:0]        mask;

  always_comb begin
    sw        = byte_rev ? {word[7:0], word[15:8], word[23:16], word[31:24]} : word;
    lg        = depth[1:0];
    base      = 5'(idx << lg);
    span_m1   = 3'((4'd1 << lg) - 4'd1);
    in_byte   = pix_msb ? 3'(~base[2:0] - span_m1) : base[2:0];
    off       = {base[4:3], in_byte};
    shifted   = sw >> off;
    mask      = 8'((9'd1 << (4'd1 << lg)) - 9'd1);
    use_table = (depth <= DEPTH_8);
    table_idx = shifted[7:0] & mask;
    half_pix  = idx[0] ? sw[31:16] : sw[15:0];
    true_pix  = sw[23:0];
  end
endmodule

// File: rtl/lcd_pixel_unpacker.sv
module lcd_pixel_unpacker
  import lpu_pkg::*;
#(
  parameter int PAL_ENTRIES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  cfg_depth,
  input  logic        cfg_byte_rev,
  input  logic        cfg_pix_msb,
  input  logic        cfg_rb_swap,
  input  logic        word_valid,
  input  logic [31:0] word_data,
  output logic        word_ready,
  input  logic        pix_req,
  output logic        pix_valid,
  output logic [23:0] pix_rgb,
  output logic        underflow,
  input  logic        pal_we,
  input  logic [6:0]  pal_waddr,
  input  logic [31:0] pal_wdata
);
  localparam int PAL_AW = $clog2(PAL_ENTRIES);

  logic              rst_n_int;
  logic [WORD_W-1:0] cur_word;
  logic [IDX_W-1:0]  cur_idx;
  logic              consume, starve;
  logic              use_table;
  logic [7:0]        table_idx;
  logic [15:0]       half_pix, table_color;
  logic [23:0]       true_pix;
  rgb_t              color, color_out;

  logic              valid_q, under_q;
  rgb_t              rgb_q;

  lpu_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  lpu_word_buf u_buf (
    .clk(clk), .rst_n(rst_n_int), .depth(cfg_depth),
    .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
    .pix_req(pix_req), .cur_word(cur_word), .cur_idx(cur_idx),
    .consume(consume), .starve(starve)
  );

  lpu_pixel_select u_sel (
    .word(cur_word), .idx(cur_idx), .depth(cfg_depth),
    .byte_rev(cfg_byte_rev), .pix_msb(cfg_pix_msb),
    .use_table(use_table), .table_idx(table_idx),
    .half_pix(half_pix), .true_pix(true_pix)
  );

  lpu_palette #(.ENTRIES(PAL_ENTRIES)) u_pal (
    .clk(clk), .we(pal_we), .waddr(pal_waddr[PAL_AW-2:0]), .wdata(pal_wdata),
    .raddr(table_idx[PAL_AW-1:0]), .rdata(table_color)
  );

  always_comb begin
    if (use_table)                color = widen565(table_color);
    else if (cfg_depth == DEPTH_16) color = widen565(half_pix);
    else                          color = rgb_t'(true_pix);
    color_out = color;
    if (cfg_rb_swap) begin
      color_out.r = color.b;
      color_out.b = color.r;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      valid_q <= 1'b0;
      under_q <= 1'b0;
      rgb_q   <= '0;
    end else begin
      valid_q <= consume;
      under_q <= starve;
      if (consume) rgb_q <= color_out;
    end
  end

  assign pix_valid = valid_q;
  assign underflow = under_q;
  assign pix_rgb   = rgb_q;
endmodule

// File: rtl/lpu_checker.sv
module lpu_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] cfg_depth,
  input logic       word_valid,
  input logic       word_ready,
  input logic       pix_req,
  input logic       pix_valid,
  input logic       underflow
);
  a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_valid && underflow));

  a_r10_answer: assert property (@(posedge clk) disable iff (!rst_n)
    pix_req |=> (pix_valid || underflow));

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_req |=> (!pix_valid && !underflow));

  a_r3_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready && cfg_depth <= 3'd4) |=> (!word_ready || pix_req));

  a_r2_single_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready && cfg_depth >= 3'd5) ##1 $stable(cfg_depth)
      |-> (word_ready == pix_req));
endmodule

bind lcd_pixel_unpacker lpu_checker u_chk (
  .clk(clk), .rst_n(rst_n_int), .cfg_depth(cfg_depth),
  .word_valid(word_valid), .word_ready(word_ready), .pix_req(pix_req),
  .pix_valid(pix_valid), .underflow(underflow)
);

// File: tb/lcd_pixel_unpacker_bench.sv
module lcd_pixel_unpacker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_depth = 3'd0;
  logic        cfg_byte_rev = 1'b0, cfg_pix_msb = 1'b0, cfg_rb_swap = 1'b0;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic        word_ready;
  logic        pix_req = 1'b0;
  logic        pix_valid;
  logic [23:0] pix_rgb;
  logic        underflow;
  logic        pal_we = 1'b0;
  logic [6:0]  pal_waddr = '0;
  logic [31:0] pal_wdata = '0;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  logic [15:0] pal_m [256];

  always #10 clk = ~clk;

  lcd_pixel_unpacker u_lcd_pixel_unpacker (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_byte_rev(cfg_byte_rev),
    .cfg_pix_msb(cfg_pix_msb), .cfg_rb_swap(cfg_rb_swap), .word_valid(word_valid),
    .word_data(word_data), .word_ready(word_ready), .pix_req(pix_req),
    .pix_valid(pix_valid), .pix_rgb(pix_rgb), .underflow(underflow),
    .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] widen(input logic [15:0] c);
    logic [7:0] r, g, b;
    r = (8'(c[15:11]) << 3) | (8'(c[15:11]) >> 2);
    g = (8'(c[10:5]) << 2) | (8'(c[10:5]) >> 4);
    b = (8'(c[4:0]) << 3) | (8'(c[4:0]) >> 2);
    return {r, g, b};
  endfunction

  function automatic logic [23:0] model(input logic [31:0] w, input int d,
                                        input bit bb, input bit bp, input bit sw, input int i);
    logic [7:0]  by [4];
    logic [23:0] rgb;
    logic [7:0]  ix;
    for (int b = 0; b < 4; b++) by[b] = bb ? w[8*(3-b) +: 8] : w[8*b +: 8];
    if (d <= 3) begin
      int bpp = 1 << d;
      int ppb = 8 / bpp;
      int bi = i / ppb;
      int k = i % ppb;
      int pos = bp ? 8 - (k + 1) * bpp : k * bpp;
      ix = '0;
      for (int j = 0; j < bpp; j++) ix[j] = by[bi][pos + j];
      rgb = widen(pal_m[ix]);
    end else if (d == 4) begin
      rgb = widen({by[2*i+1], by[2*i]});
    end else begin
      rgb = {by[2], by[1], by[0]};
    end
    if (sw) rgb = {rgb[7:0], rgb[15:8], rgb[23:16]};
    return rgb;
  endfunction

  function automatic int npix(input int d);
    return (d >= 5) ? 1 : 32 >> d;
  endfunction

  task automatic pal_write(input int a, input logic [31:0] data);
    @(negedge clk);
    pal_we = 1; pal_waddr = 7'(a); pal_wdata = data;
    @(negedge clk);
    pal_we = 0;
    pal_m[2*a]   = data[15:0];
    pal_m[2*a+1] = data[31:16];
  endtask

  task automatic push(input logic [31:0] w, input string req);
    @(negedge clk);
    word_valid = 1; word_data = w;
    #1 chk(req, 32'(word_ready), 32'd1);
    @(negedge clk);
    word_valid = 0;
  endtask

  // Push one word and drain every pixel, checking each against the model
  task automatic run_word(input logic [31:0] w, input int d, input bit bb, input bit bp,
                          input bit sw, input string req);
    int n;
    cfg_depth = 3'(d); cfg_byte_rev = bb; cfg_pix_msb = bp; cfg_rb_swap = sw;
    n = npix(d);
    push(w, req);
    if (n > 1) chk({req, " R3 ready low mid-word"}, 32'(word_ready), 32'd0);
    for (int i = 0; i < n; i++) begin
      pix_req = 1;
      #1 if (i == n - 1) chk({req, " R11 ready at last request"}, 32'(word_ready), 32'd1);
      @(negedge clk);
      pix_req = 0;
      chk({req, " R10 valid"}, 32'(pix_valid), 32'd1);
      chk(req, 32'(pix_rgb), 32'(model(w, d, bb, bp, sw, i)));
    end
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 ready", 32'(word_ready), 32'd1);
    chk("R1 valid", 32'(pix_valid), 32'd0);
    chk("R1 underflow", 32'(underflow), 32'd0);
  endtask

  task automatic t_palette();
    for (int a = 0; a < 128; a++) begin
      logic [15:0] lo, hi;
      lo = 16'((2*a) * 16'h9E37) ^ 16'h1234;
      hi = 16'((2*a+1) * 16'h9E37) ^ 16'h1234;
      pal_write(a, {hi, lo});
    end
    run_word(32'hFF_FE_01_00, 3, 0, 0, 0, "R9 R6 table both halves");
    run_word(32'h80_7F_41_C2, 3, 0, 1, 0, "R4 R6 8bpp msb-order no effect");
  endtask

  task automatic t_low_depths();
    run_word(32'hA5C3_1E69, 0, 0, 0, 0, "R2 R4 1bpp lsb");
    run_word(32'hA5C3_1E69, 0, 0, 1, 0, "R4 1bpp msb");
    run_word(32'h1B6C_E4D2, 1, 0, 0, 0, "R2 R4 2bpp lsb");
    run_word(32'h1B6C_E4D2, 1, 0, 1, 0, "R4 2bpp msb");
    run_word(32'h7E3F_9C21, 2, 0, 0, 0, "R2 R4 4bpp lsb");
    run_word(32'h7E3F_9C21, 2, 0, 1, 0, "R4 4bpp msb");
  endtask

  task automatic t_byte_rev();
    run_word(32'h0312_A0F5, 3, 1, 0, 0, "R5 8bpp reversed");
    run_word(32'h7E3F_9C21, 2, 1, 1, 0, "R5 4bpp reversed msb");
    run_word(32'hF81F_07E0, 4, 1, 0, 0, "R5 16bpp reversed");
  endtask

  task automatic t_direct();
    run_word(32'hF800_07E1, 4, 0, 0, 0, "R7 16bpp");
    run_word(32'hF800_07E1, 4, 0, 1, 0, "R4 R7 16bpp msb-order no effect");
    run_word(32'h5A12_3456, 5, 0, 0, 0, "R7 24bpp");
    run_word(32'h5A12_3456, 6, 0, 0, 0, "R2 code 6 as 24bpp");
    run_word(32'h0012_3456, 7, 1, 0, 0, "R2 R5 code 7 reversed");
  endtask

  task automatic t_swap();
    run_word(32'h00AB_CDEF, 5, 0, 0, 1, "R8 24bpp swap");
    run_word(32'hF800_001F, 4, 0, 0, 1, "R8 16bpp swap");
    run_word(32'h0005_0A11, 3, 0, 0, 1, "R8 table swap");
  endtask

  task automatic t_underflow();
    @(negedge clk);
    pix_req = 1;
    @(negedge clk);
    pix_req = 0;
    chk("R10 underflow raised", 32'(underflow), 32'd1);
    chk("R10 no pixel on underflow", 32'(pix_valid), 32'd0);
    @(negedge clk);
    chk("R10 underflow one cycle", 32'(underflow), 32'd0);
  endtask

  task automatic t_back_to_back();
    logic [31:0] w0, w1;
    w0 = 32'h1111_F800; w1 = 32'h07E0_001F;
    cfg_depth = 3'd4; cfg_byte_rev = 0; cfg_pix_msb = 0; cfg_rb_swap = 0;
    push(w0, "R11 first push");
    @(negedge clk);
    pix_req = 1;
    @(negedge clk);
    chk("R11 pixel 0", 32'(pix_rgb), 32'(model(w0, 4, 0, 0, 0, 0)));
    word_valid = 1; word_data = w1;
    #1 chk("R11 ready with last request", 32'(word_ready), 32'd1);
    @(negedge clk);
    word_valid = 0;
    chk("R11 pixel 1", 32'(pix_rgb), 32'(model(w0, 4, 0, 0, 0, 1)));
    @(negedge clk);
    chk("R11 next word pixel 0", 32'(pix_rgb), 32'(model(w1, 4, 0, 0, 0, 0)));
    chk("R11 no underflow", 32'(underflow), 32'd0);
    @(negedge clk);
    pix_req = 0;
    chk("R11 next word pixel 1", 32'(pix_rgb), 32'(model(w1, 4, 0, 0, 0, 1)));
  endtask

  task automatic t_rewrite();
    pal_write(3, 32'h07E0_F81F);
    run_word(32'h0706_0706, 3, 0, 0, 0, "R9 rewrite pair 3");
  endtask

  initial begin
    t_reset();
    t_palette();
    t_low_depths();
    t_byte_rev();
    t_direct();
    t_swap();
    t_underflow();
    t_back_to_back();
    t_rewrite();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end
endmodule